// File: doc/BRIEF.md
# Frame Timing and Status Controller

This block keeps the frame-level status of a graphics subsystem in step with the display raster. A line tick arrives once per scanline and a frame-start strobe marks the top of every frame. From these the block keeps its own line number and enters vertical blank after the last active line. The active height is 224 lines, or 240 when the tall mode input is high. On blank entry it raises the blank and palette-access status bits and gives a one-cycle vertical interrupt pulse. If a buffer-select request is pending, it is applied at that same moment.

A second unit produces a periodic line interrupt. It counts line ticks down from a programmable interval and fires once every interval+1 lines. It is held idle while no processor enables it. It can be kept silent in the blanking region, and if so it is rearmed at each frame start. A third unit times fill operations: a fill-start strobe with a length drives an active-low busy flag low for that many clock cycles.

All inputs and outputs are plain control and status pins. There is no data stream and no handshake.

Top module: `frame_status_ctrl`

## Requirements
- R1: After reset, vblank and pal_access are 1, fb_sel is 0, fill_busy_n is 1, and vint_pulse and hint_pulse are 0. The pending buffer value is cleared, so a blank entry with no write in between leaves fb_sel at 0.
- R2: Line ticks are counted from frame start. The tick that ends the last active line moves the block into blank: vblank and pal_access go to 1 and vint_pulse is high for exactly one cycle. The last active line is line 223 (the 224th tick) when tall_mode is 0, and line 239 (the 240th tick) when tall_mode is 1.
- R3: frame_start clears vblank. It clears pal_access only when disp_mode is non-zero. With disp_mode equal to 0 (forced blank), pal_access stays 1.
- R4: A pulse on fb_wr stores fb_wr_val as the pending buffer and leaves fb_sel unchanged. fb_sel takes the pending value only on blank entry, and only if the two differ.
- R5: While at least one cpu_hint_en bit is 1, hint_pulse fires on every (hint_interval+1)-th line tick, and the countdown reloads each time it fires.
- R6: While every cpu_hint_en bit is 0, hint_pulse stays 0 and the countdown is held at hint_interval. Once an enable bit is set, the first pulse comes on the (hint_interval+1)-th following tick.
- R7: With hint_in_blank at 0, no hint_pulse fires on a tick whose line number is at or past the active height. frame_start reloads the countdown and rearms it.
- R8: With hint_in_blank at 1, hints continue through blank. frame_start leaves a running countdown untouched.
- R9: A fill_start pulse drives fill_busy_n to 0 for exactly fill_len clock cycles, with a length of 0 treated as 1. A new fill_start while busy restarts the timing with the new length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Synchronous active-low reset |
| line_tick | input | 1 | One-cycle strobe at the end of each scanline |
| frame_start | input | 1 | One-cycle strobe at the top of a frame; takes priority over line_tick |
| disp_mode | input | 2 | Display mode; 0 means forced blank |
| tall_mode | input | 1 | Selects 240 active lines instead of 224 |
| hint_interval | input | 8 | Line interrupt interval minus one |
| hint_in_blank | input | 1 | Allow line interrupts during vertical blank |
| cpu_hint_en | input | 2 | Per-processor line interrupt enables |
| fb_wr | input | 1 | Strobe writing the requested buffer select |
| fb_wr_val | input | 1 | Requested buffer select value |
| fill_start | input | 1 | Strobe starting a fill operation |
| fill_len | input | 16 | Fill duration in clock cycles |
| vblank | output | 1 | Vertical blank status |
| pal_access | output | 1 | Palette access permitted status |
| fb_sel | output | 1 | Visible buffer select |
| fill_busy_n | output | 1 | Active-low fill busy flag |
| vint_pulse | output | 1 | One-cycle vertical interrupt request |
| hint_pulse | output | 1 | One-cycle line interrupt request |

## Verification
The assertions assume that frame_start and line_tick are single-cycle strobes. They also assume that consecutive line ticks are at least one idle cycle apart, so a vertical pulse can never be followed straight away by a second blank entry. The directed stimulus always drops each strobe one cycle after raising it and leaves an idle cycle between ticks. It changes cpu_hint_en, hint_interval and fill_len only while no strobe is in flight.

// File: rtl/ftsc_pkg.sv
package ftsc_pkg;
  localparam int LINES_STD  = 224;
  localparam int LINES_TALL = 240;

  typedef enum logic [1:0] {
    HI_IDLE  = 2'd0,
    HI_COUNT = 2'd1,
    HI_PARK  = 2'd2
  } hint_state_t;
endpackage

// File: rtl/ftsc_frame_track.sv
module ftsc_frame_track #(
  parameter int LINE_W = 9,
  parameter int MODE_W = 2,
  parameter int H_STD  = 224,
  parameter int H_TALL = 240
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              line_tick,
  input  logic              frame_start,
  input  logic              tall_mode,
  input  logic [MODE_W-1:0] disp_mode,
  input  logic              fb_wr,
  input  logic              fb_wr_val,
  output logic              in_blank,
  output logic              vblank,
  output logic              pal_access,
  output logic              fb_sel,
  output logic              vint_pulse
);
  localparam logic [LINE_W-1:0] LAST_STD  = LINE_W'(H_STD - 1);
  localparam logic [LINE_W-1:0] LAST_TALL = LINE_W'(H_TALL - 1);
  localparam logic [LINE_W-1:0] LINE_MAX  = '1;

  logic [LINE_W-1:0] line_num;
  logic [LINE_W-1:0] last_line;
  logic              fb_pend;
  logic              entry;

  assign last_line = tall_mode ? LAST_TALL : LAST_STD;
  assign in_blank  = line_num > last_line;
  assign entry     = line_tick && !frame_start && (line_num == last_line);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      line_num   <= LINE_MAX;
      vblank     <= 1'b1;
      pal_access <= 1'b1;
      fb_sel     <= 1'b0;
      vint_pulse <= 1'b0;
    end else begin
      vint_pulse <= 1'b0;
      if (frame_start) begin
        line_num <= '0;
        vblank   <= 1'b0;
        if (disp_mode != '0) pal_access <= 1'b0;
      end else if (line_tick) begin
        if (line_num != LINE_MAX) line_num <= line_num + 1'b1;
        if (entry) begin
          vblank     <= 1'b1;
          pal_access <= 1'b1;
          vint_pulse <= 1'b1;
          if (fb_pend != fb_sel) fb_sel <= fb_pend;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     fb_pend <= 1'b0;
    else if (fb_wr) fb_pend <= fb_wr_val;
  end

  AST_VINT_IN_BLANK: assert property (@(posedge clk) disable iff (!rst_n)
    vint_pulse |-> (vblank && pal_access)); // R2
  AST_VINT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    vint_pulse |=> !vint_pulse); // R2
  AST_FRAME_CLEARS_VBLANK: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> !vblank); // R3
  AST_FB_ONLY_AT_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    (fb_sel != $past(fb_sel)) |-> vint_pulse); // R4
endmodule

// File: rtl/ftsc_line_irq.sv
module ftsc_line_irq
  import ftsc_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int NCPU  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             line_tick,
  input  logic             frame_start,
  input  logic             in_blank,
  input  logic             blank_en,
  input  logic [NCPU-1:0]  cpu_en,
  input  logic [CNT_W-1:0] interval,
  output logic             hint_pulse
);
  hint_state_t      state;
  logic [CNT_W-1:0] cnt;
  logic             any_en;

  assign any_en = |cpu_en;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= HI_IDLE;
      cnt        <= '0;
      hint_pulse <= 1'b0;
    end else begin
      hint_pulse <= 1'b0;
      if (!any_en) begin
        state <= HI_IDLE;
        cnt   <= interval;
      end else if (frame_start) begin
        if (!blank_en || state != HI_COUNT) begin
          cnt   <= interval;
          state <= HI_COUNT;
        end
      end else if (state == HI_IDLE) begin
        state <= HI_COUNT;
        if (line_tick) begin
          if (cnt == '0) begin
            hint_pulse <= 1'b1;
            cnt        <= interval;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
      end else if (state == HI_COUNT && line_tick) begin
        if (in_blank && !blank_en) begin
          state <= HI_PARK;
        end else if (cnt == '0) begin
          hint_pulse <= 1'b1;
          cnt        <= interval;
        end else begin
          cnt <= cnt - 1'b1;
        end
      end
    end
  end

  AST_HINT_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    hint_pulse |-> $past(line_tick)); // R5
  AST_HINT_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    hint_pulse |-> $past(any_en)); // R6
  AST_HINT_BLANK_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    hint_pulse |-> $past(!in_blank || blank_en)); // R7
endmodule

// File: rtl/ftsc_fill_timer.sv
module ftsc_fill_timer #(
  parameter int LEN_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fill_start,
  input  logic [LEN_W-1:0] fill_len,
  output logic             busy_n
);
  localparam logic [LEN_W-1:0] ONE = LEN_W'(1);

  logic [LEN_W-1:0] remain;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_n <= 1'b1;
      remain <= '0;
    end else if (fill_start) begin
      busy_n <= 1'b0;
      remain <= fill_len;
    end else if (!busy_n) begin
      if (remain <= ONE) busy_n <= 1'b1;
      else               remain <= remain - ONE;
    end
  end

  AST_FILL_GOES_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    fill_start |=> !busy_n); // R9
endmodule

// File: rtl/frame_status_ctrl.sv
module frame_status_ctrl
  import ftsc_pkg::*;
#(
  parameter int LINE_W = 9,
  parameter int MODE_W = 2,
  parameter int CNT_W  = 8,
  parameter int NCPU   = 2,
  parameter int LEN_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              line_tick,
  input  logic              frame_start,
  input  logic [MODE_W-1:0] disp_mode,
  input  logic              tall_mode,
  input  logic [CNT_W-1:0]  hint_interval,
  input  logic              hint_in_blank,
  input  logic [NCPU-1:0]   cpu_hint_en,
  input  logic              fb_wr,
  input  logic              fb_wr_val,
  input  logic              fill_start,
  input  logic [LEN_W-1:0]  fill_len,
  output logic              vblank,
  output logic              pal_access,
  output logic              fb_sel,
  output logic              fill_busy_n,
  output logic              vint_pulse,
  output logic              hint_pulse
);
  logic in_blank;

  ftsc_frame_track #(
    .LINE_W(LINE_W), .MODE_W(MODE_W), .H_STD(LINES_STD), .H_TALL(LINES_TALL)
  ) u_track (
    .clk(clk), .rst_n(rst_n), .line_tick(line_tick), .frame_start(frame_start),
    .tall_mode(tall_mode), .disp_mode(disp_mode), .fb_wr(fb_wr),
    .fb_wr_val(fb_wr_val), .in_blank(in_blank), .vblank(vblank),
    .pal_access(pal_access), .fb_sel(fb_sel), .vint_pulse(vint_pulse)
  );

  ftsc_line_irq #(.CNT_W(CNT_W), .NCPU(NCPU)) u_hint (
    .clk(clk), .rst_n(rst_n), .line_tick(line_tick), .frame_start(frame_start),
    .in_blank(in_blank), .blank_en(hint_in_blank), .cpu_en(cpu_hint_en),
    .interval(hint_interval), .hint_pulse(hint_pulse)
  );

  ftsc_fill_timer #(.LEN_W(LEN_W)) u_fill (
    .clk(clk), .rst_n(rst_n), .fill_start(fill_start), .fill_len(fill_len),
    .busy_n(fill_busy_n)
  );

  AST_RESET_STATUS: assert property (@(posedge clk)
    $past(!rst_n) |-> (vblank && pal_access && !fb_sel && fill_busy_n)); // R1
endmodule

// File: tb/sim_frame_status_ctrl.sv
module sim_frame_status_ctrl;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        line_tick = 1'b0, frame_start = 1'b0;
  logic [1:0]  disp_mode = 2'd1;
  logic        tall_mode = 1'b0;
  logic [7:0]  hint_interval = 8'd3;
  logic        hint_in_blank = 1'b1;
  logic [1:0]  cpu_hint_en = 2'b00;
  logic        fb_wr = 1'b0, fb_wr_val = 1'b0;
  logic        fill_start = 1'b0;
  logic [15:0] fill_len = 16'd0;
  logic        vblank, pal_access, fb_sel, fill_busy_n, vint_pulse, hint_pulse;

  int n_vec = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  frame_status_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .line_tick(line_tick), .frame_start(frame_start),
    .disp_mode(disp_mode), .tall_mode(tall_mode), .hint_interval(hint_interval),
    .hint_in_blank(hint_in_blank), .cpu_hint_en(cpu_hint_en), .fb_wr(fb_wr),
    .fb_wr_val(fb_wr_val), .fill_start(fill_start), .fill_len(fill_len),
    .vblank(vblank), .pal_access(pal_access), .fb_sel(fb_sel),
    .fill_busy_n(fill_busy_n), .vint_pulse(vint_pulse), .hint_pulse(hint_pulse)
  );

  task automatic check(string req, int act, int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick(output logic h, output logic v);
    @(negedge clk); line_tick = 1'b1;
    @(negedge clk); line_tick = 1'b0;
    h = hint_pulse; v = vint_pulse;
  endtask

  task automatic ticks(int n, output int hc, output int vc);
    logic h, v;
    hc = 0; vc = 0;
    for (int i = 0; i < n; i++) begin
      tick(h, v);
      hc += int'(h); vc += int'(v);
    end
  endtask

  task automatic new_frame();
    @(negedge clk); frame_start = 1'b1;
    @(negedge clk); frame_start = 1'b0;
  endtask

  task automatic reload_hint(logic [1:0] en);
    @(negedge clk); cpu_hint_en = 2'b00;
    @(negedge clk); cpu_hint_en = en;
    @(negedge clk);
  endtask

  task automatic t_reset();
    check("R1 vblank", int'(vblank), 1);
    check("R1 pal_access", int'(pal_access), 1);
    check("R1 fb_sel", int'(fb_sel), 0);
    check("R1 fill_busy_n", int'(fill_busy_n), 1);
    check("R1 pulses", int'(vint_pulse | hint_pulse), 0);
  endtask

  task automatic t_vblank_std();
    int hc, vc; logic h, v;
    disp_mode = 2'd1; tall_mode = 1'b0;
    new_frame();
    check("R3 vblank cleared", int'(vblank), 0);
    check("R3 pal cleared mode!=0", int'(pal_access), 0);
    ticks(223, hc, vc);
    check("R2 no early vint", vc, 0);
    check("R2 still active", int'(vblank), 0);
    check("R6 no hint while masked", hc, 0);
    tick(h, v);
    check("R2 vint at 224th tick", int'(v), 1);
    check("R2 vblank set", int'(vblank), 1);
    check("R2 pal set", int'(pal_access), 1);
    check("R1 no pending fb after reset", int'(fb_sel), 0);
    @(negedge clk);
    check("R2 vint one cycle", int'(vint_pulse), 0);
  endtask

  task automatic t_forced_blank();
    disp_mode = 2'd0;
    new_frame();
    check("R3 vblank cleared forced", int'(vblank), 0);
    check("R3 pal kept forced", int'(pal_access), 1);
    disp_mode = 2'd1;
  endtask

  task automatic t_tall();
    int hc, vc; logic h, v;
    tall_mode = 1'b1;
    new_frame();
    ticks(239, hc, vc);
    check("R2 tall no vint at 239", vc, 0);
    check("R2 tall active", int'(vblank), 0);
    tick(h, v);
    check("R2 tall vint at 240th", int'(v), 1);
    check("R2 tall vblank", int'(vblank), 1);
    tall_mode = 1'b0;
  endtask

  task automatic t_fb();
    int hc, vc;
    new_frame();
    @(negedge clk); fb_wr = 1'b1; fb_wr_val = 1'b1;
    @(negedge clk); fb_wr = 1'b0;
    check("R4 fb held pending", int'(fb_sel), 0);
    ticks(223, hc, vc);
    check("R4 fb held before entry", int'(fb_sel), 0);
    ticks(1, hc, vc);
    check("R4 fb applied at entry", int'(fb_sel), 1);
    new_frame();
    check("R4 fb kept at frame start", int'(fb_sel), 1);
    @(negedge clk); fb_wr = 1'b1; fb_wr_val = 1'b0;
    @(negedge clk); fb_wr = 1'b0;
    ticks(224, hc, vc);
    check("R4 fb back to 0", int'(fb_sel), 0);
  endtask

  task automatic t_hint_period();
    logic h, v;
    hint_in_blank = 1'b1; hint_interval = 8'd3;
    reload_hint(2'b01);
    for (int k = 1; k <= 12; k++) begin
      tick(h, v);
      check($sformatf("R5 hint tick %0d", k), int'(h), int'(k % 4 == 0));
    end
  endtask

  task automatic t_hint_masked();
    int hc, vc; logic h, v;
    @(negedge clk); cpu_hint_en = 2'b00;
    ticks(10, hc, vc);
    check("R6 masked no hint", hc, 0);
    @(negedge clk); cpu_hint_en = 2'b10;
    @(negedge clk);
    for (int k = 1; k <= 4; k++) begin
      tick(h, v);
      check($sformatf("R6 fresh count tick %0d", k), int'(h), int'(k == 4));
    end
  endtask

  task automatic t_hint_blank_off();
    int early = 0, late = 0, pos_bad = 0; logic h, v;
    hint_in_blank = 1'b0; hint_interval = 8'd9; tall_mode = 1'b0;
    reload_hint(2'b01);
    new_frame();
    for (int k = 1; k <= 260; k++) begin
      tick(h, v);
      if (k <= 224) begin
        early += int'(h);
        if (h != (k % 10 == 0)) pos_bad++;
      end else late += int'(h);
    end
    check("R7 hints in active area", early, 22);
    check("R7 hint positions", pos_bad, 0);
    check("R7 none in blank", late, 0);
    new_frame();
    for (int k = 1; k <= 10; k++) begin
      tick(h, v);
      check($sformatf("R7 rearmed tick %0d", k), int'(h), int'(k == 10));
    end
  endtask

  task automatic t_hint_blank_on();
    int hc, vc; logic h, v;
    hint_in_blank = 1'b1; hint_interval = 8'd9;
    reload_hint(2'b01);
    new_frame();
    ticks(5, hc, vc);
    check("R8 none before frame", hc, 0);
    new_frame();
    ticks(4, hc, vc);
    check("R8 not restarted", hc, 0);
    tick(h, v);
    check("R8 hint at 10th overall", int'(h), 1);
    reload_hint(2'b01);
    new_frame();
    ticks(229, hc, vc);
    tick(h, v);
    check("R8 hint count through blank", hc + int'(h), 23);
    check("R8 hint inside blank", int'(h), 1);
  endtask

  task automatic fill_run(logic [15:0] len, output int n);
    fill_len = len;
    @(negedge clk); fill_start = 1'b1;
    @(negedge clk); fill_start = 1'b0;
    n = 0;
    while (!fill_busy_n && n < 1000) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic t_fill();
    int n;
    fill_run(16'd5, n);
    check("R9 fill len 5", n, 5);
    fill_run(16'd0, n);
    check("R9 fill len 0", n, 1);
    fill_len = 16'd10;
    @(negedge clk); fill_start = 1'b1;
    @(negedge clk); fill_start = 1'b0;
    n = 0;
    for (int i = 0; i < 3; i++) begin
      n += int'(!fill_busy_n);
      if (i == 2) begin fill_start = 1'b1; fill_len = 16'd4; end
      @(negedge clk);
    end
    fill_start = 1'b0;
    while (!fill_busy_n && n < 1000) begin
      n++;
      @(negedge clk);
    end
    check("R9 fill restart", n, 7);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_vblank_std();
    t_forced_blank();
    t_tall();
    t_fb();
    t_hint_period();
    t_hint_masked();
    t_hint_blank_off();
    t_hint_blank_on();
    t_fill();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule